// File: doc/BRIEF.md
# RAM-Coefficient Decimating FIR Filter

This block filters and decimates a stream of complex baseband samples. I and Q arrive together on one input beat. Every accepted beat is written into a circular sample memory. Each time a programmable number of beats has arrived, one multiply-accumulate engine walks back through the stored history, one tap per clock. It multiplies each sample by a 20-bit signed coefficient held in a writable coefficient memory. I and Q are accumulated side by side with the same coefficient.

When the walk ends, both sums are rounded and saturated to 16 bits and presented as a single output beat. A long filter therefore costs many clocks per output. The usable tap count shrinks as the output rate rises.

The host fills the coefficient memory through a simple write port while the engine is idle. It sets the tap count (up to 160) and the decimation factor (1 to 256) on static configuration pins.

The input side uses valid/ready. `in_ready` is low only during reset and never applies back-pressure afterwards, so a beat is accepted on every clock edge where `in_valid` is high. The output side has no ready: `out_valid` is a one-cycle pulse and the consumer must take the beat in that cycle. A computation that falls due while the engine is still working is dropped and flagged on `overrun`.

Top module: `rcf_dec_fir`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `busy`, `overrun` and `in_ready` are all 0.
- R2: A phase counter counts accepted beats. The beat accepted while the counter is greater than or equal to `cfg_dec` starts a computation and clears the counter; any other accepted beat increments it. The decimation factor is therefore `cfg_dec + 1`, and the counter is cleared only by reset or by a start.
- R3: Each output equals the sum over k = 0 .. T-1 of coef[k] × x[n-k], where x[n] is the beat that started the computation (newest first) and T is the effective tap count. The sum is formed for I and Q separately, using the same coefficients.
- R4: Each sum is rounded by adding 2^18 and then shifting right arithmetically by 19 bits.
- R5: A rounded result above 32767 is output as 32767, and one below -32768 as -32768.
- R6: `cfg_taps` is sampled when a computation starts. A value of 0 means 1 tap, and values above 160 mean 160 taps.
- R7: After a start on clock edge e with T effective taps, `out_valid` is high for exactly one cycle, following edge e+T+1. `busy` is high from edge e+1 and drops on the same edge that `out_valid` rises.
- R8: A start that falls due while `busy` is high is dropped: no output is produced for it, and `overrun` pulses high for one cycle after that edge.
- R9: A coefficient write (`cfg_coef_we`) on an edge where `busy` is high is ignored, and so is a write to any address of 160 or more. The stored coefficients are then unchanged for later computations.
- R10: `in_ready` rises on the first clock edge after reset is released and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_coef_we | input | 1 | Coefficient write strobe |
| cfg_coef_addr | input | 8 | Coefficient index (tap number) |
| cfg_coef_data | input | 20 | Signed coefficient value |
| cfg_taps | input | 8 | Tap count, sampled at each start |
| cfg_dec | input | 8 | Decimation factor minus one |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat ready |
| in_i | input | 16 | Input in-phase sample, signed |
| in_q | input | 16 | Input quadrature sample, signed |
| out_valid | output | 1 | One-cycle output strobe |
| out_i | output | 16 | Filtered in-phase result, signed |
| out_q | output | 16 | Filtered quadrature result, signed |
| busy | output | 1 | Engine computing or emitting |
| overrun | output | 1 | One-cycle pulse for a dropped start |

## Verification
On every cycle, the assertions check the following:
- the output strobe lasts a single cycle and `busy` ends exactly when a result appears;
- an overrun pulse only follows a cycle in which the engine was busy;
- the latched tap limit stays within the memory;
- a blocked coefficient write leaves the addressed word untouched;
- the write pointer stays inside the ring and `in_ready` never falls once raised.

Only the bench scenarios can show the arithmetic: the newest-first order of the sum, rounding, saturation and tap clamping. The same holds for which starts are dropped when the decimation interval is shorter than the computation. The bench predicts all of these from its own sample history and coefficient copy.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_EMIT = 2'd2
  } eng_state_e;
endpackage

// File: rtl/rcf_coef_store.sv
module rcf_coef_store #(
  parameter int COEF_W = 20,
  parameter int DEPTH  = 160,
  parameter int AW     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     lock,
  input  logic [AW-1:0]            wr_addr,
  input  logic signed [COEF_W-1:0] wr_data,
  input  logic [AW-1:0]            rd_addr,
  output logic signed [COEF_W-1:0] rd_data
);
  localparam logic [AW-1:0] DEPTH_L = AW'(DEPTH);

  logic signed [COEF_W-1:0] mem [DEPTH];
  logic wr_ok;

  assign wr_ok   = wr_en && !lock && (wr_addr < DEPTH_L);
  assign rd_data = (rd_addr < DEPTH_L) ? mem[rd_addr] : '0;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= wr_data;
  end

  // R9: a locked write must not disturb the addressed word
  p_locked_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock && (wr_addr < DEPTH_L)) |=> (mem[$past(wr_addr)] == $past(mem[wr_addr])));
endmodule

// File: rtl/rcf_sample_ring.sv
module rcf_sample_ring #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 320,
  parameter int AW     = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic signed [DATA_W-1:0] wr_i,
  input  logic signed [DATA_W-1:0] wr_q,
  output logic [AW-1:0]            wr_ptr,
  input  logic [AW-1:0]            rd_ptr,
  output logic signed [DATA_W-1:0] rd_i,
  output logic signed [DATA_W-1:0] rd_q
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW-1:0] DEPTH_L = AW'(DEPTH);

  logic [2*DATA_W-1:0] mem [DEPTH];
  logic [2*DATA_W-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
    end else if (wr_en) begin
      wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= {wr_i, wr_q};
  end

  assign rd_word = mem[rd_ptr];
  assign rd_i    = rd_word[2*DATA_W-1:DATA_W];
  assign rd_q    = rd_word[DATA_W-1:0];

  // R2: the write pointer stays inside the ring
  p_ptr_in_ring_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr < DEPTH_L);
endmodule

// File: rtl/rcf_mac_engine.sv
module rcf_mac_engine
  import rcf_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int COEF_W     = 20,
  parameter int ACC_W      = 48,
  parameter int OUT_W      = 16,
  parameter int SHIFT      = 19,
  parameter int TAPS_MAX   = 160,
  parameter int TAP_AW     = 8,
  parameter int RING_DEPTH = 320,
  parameter int RING_AW    = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [TAP_AW-1:0]        taps_cfg,
  input  logic [RING_AW-1:0]       newest,
  input  logic signed [DATA_W-1:0] smp_i,
  input  logic signed [DATA_W-1:0] smp_q,
  input  logic signed [COEF_W-1:0] coef,
  output logic [RING_AW-1:0]       rd_ptr,
  output logic [TAP_AW-1:0]        coef_addr,
  output logic                     busy,
  output logic                     overrun,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_i,
  output logic signed [OUT_W-1:0]  out_q
);
  localparam int PW = DATA_W + COEF_W;
  localparam logic [TAP_AW-1:0]  TAPS_L = TAP_AW'(TAPS_MAX);
  localparam logic [RING_AW-1:0] RING_LAST = RING_AW'(RING_DEPTH - 1);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (SHIFT - 1);
  localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) << (OUT_W - 1)) - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] MINV = ~MAXV;

  eng_state_e state;
  logic [TAP_AW-1:0] k, tap_last, taps_eff;
  logic signed [ACC_W-1:0] acc_i, acc_q;
  logic signed [PW-1:0] prod_i, prod_q;

  function automatic logic signed [OUT_W-1:0] round_sat(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] t;
    t = (a + HALF) >>> SHIFT;
    if (t > MAXV) return MAXV[OUT_W-1:0];
    if (t < MINV) return MINV[OUT_W-1:0];
    return t[OUT_W-1:0];
  endfunction

  always_comb begin
    if (taps_cfg == '0)        taps_eff = TAP_AW'(1);
    else if (taps_cfg > TAPS_L) taps_eff = TAPS_L;
    else                        taps_eff = taps_cfg;
  end

  assign prod_i    = PW'(smp_i) * PW'(coef);
  assign prod_q    = PW'(smp_q) * PW'(coef);
  assign busy      = (state != ENG_IDLE);
  assign coef_addr = k;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ENG_IDLE;
      k         <= '0;
      tap_last  <= '0;
      rd_ptr    <= '0;
      acc_i     <= '0;
      acc_q     <= '0;
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
      overrun   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      overrun   <= start && (state != ENG_IDLE);
      case (state)
        ENG_IDLE: begin
          if (start) begin
            acc_i    <= '0;
            acc_q    <= '0;
            k        <= '0;
            tap_last <= taps_eff - TAP_AW'(1);
            rd_ptr   <= newest;
            state    <= ENG_RUN;
          end
        end
        ENG_RUN: begin
          acc_i  <= acc_i + ACC_W'(prod_i);
          acc_q  <= acc_q + ACC_W'(prod_q);
          rd_ptr <= (rd_ptr == '0) ? RING_LAST : rd_ptr - RING_AW'(1);
          if (k == tap_last) state <= ENG_EMIT;
          else               k     <= k + TAP_AW'(1);
        end
        ENG_EMIT: begin
          out_i     <= round_sat(acc_i);
          out_q     <= round_sat(acc_q);
          out_valid <= 1'b1;
          state     <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  // R6: the latched tap limit never exceeds the coefficient memory
  p_tap_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tap_last < TAPS_L));
  // R7: output strobe is one cycle wide
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R7: busy ends exactly when a result is presented
  p_busy_ends_with_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> out_valid);
  // R8: an overrun pulse only follows a busy cycle
  p_overrun_when_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(busy));
  // R3: the emit step is only reached from the accumulate loop
  p_emit_after_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENG_EMIT) |-> ($past(state) == ENG_RUN));
endmodule

// File: rtl/rcf_dec_fir.sv
module rcf_dec_fir #(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 20,
  parameter int TAPS_MAX  = 160,
  parameter int DEC_MAX   = 256,
  parameter int ACC_W     = 48,
  parameter int OUT_SHIFT = 19,
  localparam int TAP_AW     = $clog2(TAPS_MAX + 1),
  localparam int DEC_W      = $clog2(DEC_MAX),
  localparam int RING_DEPTH = 2 * TAPS_MAX,
  localparam int RING_AW    = $clog2(RING_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_coef_we,
  input  logic [TAP_AW-1:0]        cfg_coef_addr,
  input  logic signed [COEF_W-1:0] cfg_coef_data,
  input  logic [TAP_AW-1:0]        cfg_taps,
  input  logic [DEC_W-1:0]         cfg_dec,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_i,
  input  logic signed [DATA_W-1:0] in_q,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q,
  output logic                     busy,
  output logic                     overrun
);
  logic accept, fire;
  logic [DEC_W-1:0] phase_cnt;
  logic [RING_AW-1:0] wr_ptr, rd_ptr;
  logic [TAP_AW-1:0] coef_addr;
  logic signed [DATA_W-1:0] smp_i, smp_q;
  logic signed [COEF_W-1:0] coef;

  assign accept = in_valid && in_ready;
  assign fire   = accept && (phase_cnt >= cfg_dec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready  <= 1'b0;
      phase_cnt <= '0;
    end else begin
      in_ready <= 1'b1;
      if (fire)        phase_cnt <= '0;
      else if (accept) phase_cnt <= phase_cnt + DEC_W'(1);
    end
  end

  rcf_coef_store #(
    .COEF_W (COEF_W),
    .DEPTH  (TAPS_MAX),
    .AW     (TAP_AW)
  ) u_coef (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_coef_we),
    .lock    (busy),
    .wr_addr (cfg_coef_addr),
    .wr_data (cfg_coef_data),
    .rd_addr (coef_addr),
    .rd_data (coef)
  );

  rcf_sample_ring #(
    .DATA_W (DATA_W),
    .DEPTH  (RING_DEPTH),
    .AW     (RING_AW)
  ) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (accept),
    .wr_i   (in_i),
    .wr_q   (in_q),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .rd_i   (smp_i),
    .rd_q   (smp_q)
  );

  rcf_mac_engine #(
    .DATA_W     (DATA_W),
    .COEF_W     (COEF_W),
    .ACC_W      (ACC_W),
    .OUT_W      (DATA_W),
    .SHIFT      (OUT_SHIFT),
    .TAPS_MAX   (TAPS_MAX),
    .TAP_AW     (TAP_AW),
    .RING_DEPTH (RING_DEPTH),
    .RING_AW    (RING_AW)
  ) u_mac (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (fire),
    .taps_cfg  (cfg_taps),
    .newest    (wr_ptr),
    .smp_i     (smp_i),
    .smp_q     (smp_q),
    .coef      (coef),
    .rd_ptr    (rd_ptr),
    .coef_addr (coef_addr),
    .busy      (busy),
    .overrun   (overrun),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
  );

  // R10: once ready, the input never stalls
  p_ready_sticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);
  // R2: a start always clears the phase counter
  p_phase_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (phase_cnt == '0));
endmodule

// File: tb/rcf_dec_fir_tb.sv
module rcf_dec_fir_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NCASE      = 8;
  // {taps[39:32], dec code[31:24], input count[23:8], pattern[7:0]}
  localparam logic [39:0] CASES [NCASE] = '{
    {8'd4,   8'd7,   16'd32,  8'd0},
    {8'd1,   8'd0,   16'd12,  8'd2},
    {8'd16,  8'd31,  16'd64,  8'd1},
    {8'd0,   8'd5,   16'd24,  8'd2},
    {8'd200, 8'd255, 16'd256, 8'd0},
    {8'd160, 8'd199, 16'd200, 8'd2},
    {8'd33,  8'd2,   16'd60,  8'd0},
    {8'd10,  8'd15,  16'd48,  8'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_coef_we = 1'b0;
  logic [7:0] cfg_coef_addr = '0;
  logic signed [19:0] cfg_coef_data = '0;
  logic [7:0] cfg_taps = 8'd1;
  logic [7:0] cfg_dec = '0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic in_ready, out_valid, busy, overrun;
  logic signed [15:0] out_i, out_q;

  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  logic signed [15:0] hi [512];
  logic signed [15:0] hq [512];
  int nh = 0;
  logic signed [19:0] mcoef [160];
  int mphase = 0;
  int last_ca = -1000, last_t = 0;
  int exp_ovr = 0, seen_ovr = 0;
  longint eq_i [256];
  longint eq_q [256];
  int eq_c [256];
  string eq_tag [256];
  int qw = 0, qr = 0;
  string cur_tag = "R3";

  rcf_dec_fir u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_coef_we(cfg_coef_we), .cfg_coef_addr(cfg_coef_addr),
    .cfg_coef_data(cfg_coef_data), .cfg_taps(cfg_taps), .cfg_dec(cfg_dec),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .busy(busy), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clamp_t(input int t);
    if (t == 0) return 1;
    if (t > 160) return 160;
    return t;
  endfunction

  function automatic bit eng_busy(input int e);
    return (e > last_ca) && (e <= last_ca + last_t + 1);
  endfunction

  function automatic longint rnd_sat(input longint a);
    longint t;
    t = (a + (longint'(1) <<< 18)) >>> 19;
    if (t > 32767) return 32767;
    if (t < -32768) return -32768;
    return t;
  endfunction

  function automatic logic signed [15:0] gen_i(input int n, input int p);
    case (p)
      0: return 16'(((n * 37) % 8000) - 4000);
      1: return 16'sd32767;
      default: return 16'(((n * 12345 + 678) % 65536) - 32768);
    endcase
  endfunction

  function automatic logic signed [15:0] gen_q(input int n, input int p);
    case (p)
      0: return 16'(3000 - ((n * 53) % 6000));
      1: return -16'sd32768;
      default: return 16'(((n * 54321 + 9) % 65536) - 32768);
    endcase
  endfunction

  function automatic logic signed [19:0] gen_c(input int k, input int p);
    case (p)
      0: return 20'(((k * 2731) % 40000) - 20000);
      1: return 20'sd524287;
      default: return 20'(((k * 9973 + 17) % 600000) - 300000);
    endcase
  endfunction

  task automatic wcoef(input int k, input logic signed [19:0] v);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_coef_we = 1'b1;
    cfg_coef_addr = 8'(k);
    cfg_coef_data = v;
    if (!eng_busy(cyc + 1) && k < 160) mcoef[k] = v;
  endtask

  task automatic send(input logic signed [15:0] si, input logic signed [15:0] sq);
    int e, t;
    longint ai, aq;
    @(negedge clk);
    cfg_coef_we = 1'b0;
    in_valid = 1'b1;
    in_i = si;
    in_q = sq;
    e = cyc + 1;
    hi[nh & 511] = si;
    hq[nh & 511] = sq;
    if (mphase >= int'(cfg_dec)) begin
      mphase = 0;
      if (eng_busy(e)) begin
        exp_ovr++;
      end else begin
        t = clamp_t(int'(cfg_taps));
        last_ca = e;
        last_t = t;
        ai = 0;
        aq = 0;
        for (int k = 0; k < t; k++) begin
          ai += longint'(mcoef[k]) * longint'(hi[(nh - k) & 511]);
          aq += longint'(mcoef[k]) * longint'(hq[(nh - k) & 511]);
        end
        eq_i[qw & 255] = rnd_sat(ai);
        eq_q[qw & 255] = rnd_sat(aq);
        eq_c[qw & 255] = e + t + 1;
        eq_tag[qw & 255] = cur_tag;
        qw++;
      end
    end else begin
      mphase++;
    end
    nh++;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_coef_we = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (overrun) seen_ovr++;
      if (out_valid) begin
        if (qr == qw) begin
          chk(1'b0, "R2 unexpected output", longint'(out_i), 0);
        end else begin
          chk(longint'(out_i) == eq_i[qr & 255], {eq_tag[qr & 255], " I result"}, longint'(out_i), eq_i[qr & 255]);
          chk(longint'(out_q) == eq_q[qr & 255], {eq_tag[qr & 255], " Q result"}, longint'(out_q), eq_q[qr & 255]);
          chk(cyc == eq_c[qr & 255], "R7 output cycle", cyc, eq_c[qr & 255]);
          qr++;
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int gn;
    gn = 0;
    for (int k = 0; k < 512; k++) begin
      hi[k] = '0;
      hq[k] = '0;
    end
    for (int k = 0; k < 160; k++) mcoef[k] = '0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(busy == 1'b0, "R1 busy in reset", busy, 0);
    chk(overrun == 1'b0, "R1 overrun in reset", overrun, 0);
    chk(in_ready == 1'b0, "R1 in_ready in reset", in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
    // fill the sample history with zeros, no start due
    cfg_taps = 8'd1;
    cfg_dec = 8'd255;
    for (int n = 0; n < 200; n++) send(16'sd0, 16'sd0);
    idle(5);
    // table-driven scenarios
    for (int c = 0; c < NCASE; c++) begin
      int t, nin, p;
      @(negedge clk);
      cfg_taps = CASES[c][39:32];
      cfg_dec = CASES[c][31:24];
      nin = int'(CASES[c][23:8]);
      p = int'(CASES[c][7:0]);
      t = clamp_t(int'(cfg_taps));
      cur_tag = $sformatf("R3 R4 R5 R6 case %0d", c);
      for (int k = 0; k < t; k++) wcoef(k, gen_c(k, p));
      for (int n = 0; n < nin; n++) begin
        send(gen_i(gn, p), gen_q(gn, p));
        gn++;
      end
      idle(200);
      chk(in_ready == 1'b1, "R10 in_ready held", in_ready, 1);
    end
    // R9: a write while busy must not alter the coefficients
    @(negedge clk);
    cfg_taps = 8'd8;
    cfg_dec = 8'd0;
    cur_tag = "R9 blocked write";
    for (int k = 0; k < 8; k++) wcoef(k, 20'(1000 * (k + 1)));
    wcoef(200, 20'sd77);
    idle(5);
    send(16'sd1000, -16'sd1000);
    wcoef(0, 20'sd500000);
    idle(20);
    send(16'sd2000, 16'sd3000);
    idle(20);
    chk(busy == 1'b0, "R7 busy low when idle", busy, 0);
    chk(qr == qw, "R2 all predicted outputs seen", qr, qw);
    chk(seen_ovr == exp_ovr, "R8 overrun pulse count", seen_ovr, exp_ovr);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule